// File: doc/BRIEF.md
# Storage Controller Enable and Reset Sequencer

This block owns the host-visible handshake that brings a storage controller up and takes it down. The host writes a configuration word whose low bit is the enable and whose next two bits request a shutdown. The block reports readiness, a fatal-error flag and a two-bit shutdown status back to the host. Three admin setup registers are also held here: the admin queue sizes and the two admin queue base addresses.

Raising the enable latches the configuration in force and starts a programmable wake-up delay, after which ready is raised. Dropping the enable first asks the command engine to drain and only lowers ready once the engine reports idle. At that point a one-cycle flush pulse tells the queue logic to delete the I/O queues and abort unfinished commands. A synchronous bus reset input does the same at once. Neither kind of controller reset touches the admin setup registers, so the host can re-enable without reprogramming them.

Top module: `ctrl_enable_seq`

## Requirements
- R1: After power-on reset (`rst_n` low), ready, fatal, drain_req and ioq_flush are 0, sd_status is 00, and every register output is zero.
- R2: A configuration write while the stored enable bit is 0 replaces the whole word. While it is 1, only bit 0 (enable) and bits [2:1] (shutdown request) take the written value, and bits [CFG_W-1:3] keep their old contents.
- R3: When enable is written to 1 from the disabled state with nonzero admin queue sizes, ready stays 0 and then rises exactly `rdy_dly`+2 clock edges after the write edge.
- R4: `act_cfg` takes bits [CFG_W-1:3] of the stored configuration at the edge where an enable is accepted. It does not follow later configuration writes.
- R5: When enable is cleared while ready, drain_req rises one edge later and ready stays 1 until `eng_idle` is seen. At that edge ready and drain_req fall, and ioq_flush is 1 for exactly the next cycle.
- R6: An enable with a zero submission-queue size (adm_size[QSZ_W-1:0]) or a zero completion-queue size (adm_size[2*QSZ_W-1:QSZ_W]) sets fatal and keeps ready at 0. Clearing enable clears fatal one edge later.
- R7: A normal shutdown request (sd_req = 01) while ready moves sd_status from 00 to 01 on the next edge and raises drain_req. sd_status moves to 10 only at an edge where `eng_idle` is 1.
- R8: An abrupt shutdown request (sd_req with bit 1 set) moves sd_status to 01 and then to 10 on the following edge, whatever `eng_idle` is.
- R9: A controller reset through the enable bit returns sd_status to 00 and leaves the admin size and base registers unchanged.
- R10: With `bus_rst` high at an edge, the next cycle shows ready 0, fatal 0, sd_status 00, drain_req 0, configuration word 0 and ioq_flush 1. The admin registers and act_cfg are kept.
- R11: Each admin register (sizes, submission base, completion base) takes its write data at the edge where its write enable is high, in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_rst | input | 1 | Synchronous external bus reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wd | input | CFG_W | Configuration write data: [0] enable, [2:1] shutdown request, rest settings |
| adm_size_we | input | 1 | Admin size register write strobe |
| adm_size_wd | input | 2*QSZ_W | Admin sizes: [QSZ_W-1:0] submission, upper half completion |
| sq_base_we | input | 1 | Admin submission base write strobe |
| sq_base_wd | input | ADDR_W | Admin submission base data |
| cq_base_we | input | 1 | Admin completion base write strobe |
| cq_base_wd | input | ADDR_W | Admin completion base data |
| rdy_dly | input | DLY_W | Wake-up delay in cycles |
| eng_idle | input | 1 | Command engine reports no work in flight |
| cfg_q | output | CFG_W | Stored configuration word |
| act_cfg | output | CFG_W-3 | Settings in force since the last accepted enable |
| adm_size_q | output | 2*QSZ_W | Stored admin sizes |
| sq_base_q | output | ADDR_W | Stored admin submission base |
| cq_base_q | output | ADDR_W | Stored admin completion base |
| ready | output | 1 | Controller ready |
| fatal | output | 1 | Fatal error status |
| sd_status | output | 2 | Shutdown status: 00 none, 01 in progress, 10 complete |
| drain_req | output | 1 | Request to the command engine to finish outstanding work |
| ioq_flush | output | 1 | One-cycle pulse: delete I/O queues, abort commands |

## Verification
A state machine stuck in its wake-up phase shows as ready staying low past the `rdy_dly`+2 edge, and an off-by-one counter shows as ready rising one edge early or late. A lost drain state shows as ready falling while `eng_idle` is still low. A wrong lock on the configuration word shows on `cfg_q` on the edge after the offending write. A controller reset that wipes too much shows as changed admin register outputs on the cycle after the flush pulse. A shutdown tracker that skips or reorders its steps shows as sd_status jumping from 00 to 10, or reaching 10 without idle, within two edges of the request.

// File: rtl/ctrl_seq_pkg.sv
package ctrl_seq_pkg;
   typedef enum logic [2:0] {
      ST_OFF   = 3'd0,
      ST_WAKE  = 3'd1,
      ST_LIVE  = 3'd2,
      ST_DRAIN = 3'd3,
      ST_FAULT = 3'd4
   } seq_state_e;

   localparam logic [1:0] SD_NONE = 2'b00;
   localparam logic [1:0] SD_BUSY = 2'b01;
   localparam logic [1:0] SD_DONE = 2'b10;

   localparam int EN_BIT   = 0;
   localparam int SDR_LO   = 1;
   localparam int FIELD_LO = 3;
endpackage

// File: rtl/cfg_bank.sv
module cfg_bank
   import ctrl_seq_pkg::*;
#(
   parameter int CFG_W  = 16,
   parameter int QSZ_W  = 12,
   parameter int ADDR_W = 32,
   localparam int ACT_W = CFG_W - FIELD_LO
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_rst,
   input  logic                 cfg_we,
   input  logic [CFG_W-1:0]     cfg_wd,
   input  logic                 size_we,
   input  logic [2*QSZ_W-1:0]   size_wd,
   input  logic                 sqb_we,
   input  logic [ADDR_W-1:0]    sqb_wd,
   input  logic                 cqb_we,
   input  logic [ADDR_W-1:0]    cqb_wd,
   input  logic                 take,
   output logic [CFG_W-1:0]     cfg_q,
   output logic [ACT_W-1:0]     act_q,
   output logic [2*QSZ_W-1:0]   size_q,
   output logic [ADDR_W-1:0]    sqb_q,
   output logic [ADDR_W-1:0]    cqb_q
);

   // configuration word: settings are frozen while enable is set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (bus_rst) begin
         cfg_q <= '0;
      end else if (cfg_we) begin
         if (cfg_q[EN_BIT])
            cfg_q <= {cfg_q[CFG_W-1:FIELD_LO], cfg_wd[FIELD_LO-1:0]};
         else
            cfg_q <= cfg_wd;
      end
   end

   // settings in force, captured only on an accepted enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    act_q <= '0;
      else if (take) act_q <= cfg_q[CFG_W-1:FIELD_LO];
   end

   // admin setup registers: no controller reset path reaches them
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q <= '0;
         sqb_q  <= '0;
         cqb_q  <= '0;
      end else begin
         if (size_we) size_q <= size_wd;
         if (sqb_we)  sqb_q  <= sqb_wd;
         if (cqb_we)  cqb_q  <= cqb_wd;
      end
   end

   AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_q[EN_BIT]) && !$past(bus_rst)) |->
      (cfg_q[CFG_W-1:FIELD_LO] == $past(cfg_q[CFG_W-1:FIELD_LO]))); // R2

   AST_ADMIN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(size_we) && !$past(sqb_we) && !$past(cqb_we)) |->
      ($stable(size_q) && $stable(sqb_q) && $stable(cqb_q))); // R9

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
   import ctrl_seq_pkg::*;
#(
   parameter int QSZ_W = 12,
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rst,
   input  logic             en,
   input  logic [QSZ_W-1:0] sq_sz,
   input  logic [QSZ_W-1:0] cq_sz,
   input  logic [DLY_W-1:0] dly,
   input  logic             eng_idle,
   output logic             take,
   output logic             ctl_rst,
   output logic             live,
   output logic             rdy,
   output logic             fault,
   output logic             drain,
   output logic             flush
);

   seq_state_e       st, nst;
   logic [DLY_W-1:0] cnt;
   logic             flush_q;

   always_comb begin
      nst     = st;
      take    = 1'b0;
      ctl_rst = 1'b0;
      if (bus_rst) begin
         nst     = ST_OFF;
         ctl_rst = 1'b1;
      end else begin
         unique case (st)
            ST_OFF: if (en) begin
               if (sq_sz == '0 || cq_sz == '0) begin
                  nst = ST_FAULT;
               end else begin
                  nst  = ST_WAKE;
                  take = 1'b1;
               end
            end
            ST_WAKE: if (!en) begin
               nst     = ST_OFF;
               ctl_rst = 1'b1;
            end else if (cnt == dly) begin
               nst = ST_LIVE;
            end
            ST_LIVE: if (!en) nst = ST_DRAIN;
            ST_DRAIN: if (eng_idle) begin
               nst     = ST_OFF;
               ctl_rst = 1'b1;
            end
            ST_FAULT: if (!en) begin
               nst     = ST_OFF;
               ctl_rst = 1'b1;
            end
            default: nst = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_OFF;
         cnt     <= '0;
         flush_q <= 1'b0;
      end else begin
         st      <= nst;
         flush_q <= ctl_rst;
         cnt     <= (st == ST_WAKE && nst == ST_WAKE) ? cnt + 1'b1 : '0;
      end
   end

   assign live  = (st == ST_LIVE);
   assign rdy   = (st == ST_LIVE) || (st == ST_DRAIN);
   assign fault = (st == ST_FAULT);
   assign drain = (st == ST_DRAIN);
   assign flush = flush_q;

   AST_RDY_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy) |-> ($past(eng_idle) || $past(bus_rst))); // R5

   AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (drain && !eng_idle && !bus_rst) |=> (drain && rdy)); // R5

   AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault) |-> ($past(sq_sz) == '0 || $past(cq_sz) == '0)); // R6

   AST_RDY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy) |-> $past(en)); // R3

endmodule

// File: rtl/sd_track.sv
module sd_track
   import ctrl_seq_pkg::*;
#(
   parameter bit ABRUPT_SKIPS_DRAIN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       live,
   input  logic [1:0] sd_req,
   input  logic       eng_idle,
   output logic [1:0] sd_status
);

   logic abr_q;
   logic done_ok;

   generate
      if (ABRUPT_SKIPS_DRAIN) begin : g_abrupt_fast
         assign done_ok = abr_q | eng_idle;
      end else begin : g_abrupt_waits
         assign done_ok = eng_idle;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sd_status <= SD_NONE;
         abr_q     <= 1'b0;
      end else if (clr) begin
         sd_status <= SD_NONE;
         abr_q     <= 1'b0;
      end else begin
         case (sd_status)
            SD_NONE: if (live && sd_req != 2'b00) begin
               sd_status <= SD_BUSY;
               abr_q     <= sd_req[1];
            end
            SD_BUSY: if (done_ok) sd_status <= SD_DONE;
            default: ;
         endcase
      end
   end

   AST_SD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_status == SD_DONE) |-> ($past(sd_status) != SD_NONE)); // R7

   AST_SD_NORMAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sd_status) == SD_BUSY && sd_status == SD_DONE && !$past(abr_q))
      |-> $past(eng_idle)); // R7

   AST_SD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      sd_status != 2'b11); // R8

endmodule

// File: rtl/ctrl_enable_seq.sv
module ctrl_enable_seq
   import ctrl_seq_pkg::*;
#(
   parameter int CFG_W  = 16,
   parameter int QSZ_W  = 12,
   parameter int ADDR_W = 32,
   parameter int DLY_W  = 8,
   parameter bit ABRUPT_SKIPS_DRAIN = 1'b1,
   localparam int ACT_W = CFG_W - FIELD_LO
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_rst,
   input  logic                cfg_we,
   input  logic [CFG_W-1:0]    cfg_wd,
   input  logic                adm_size_we,
   input  logic [2*QSZ_W-1:0]  adm_size_wd,
   input  logic                sq_base_we,
   input  logic [ADDR_W-1:0]   sq_base_wd,
   input  logic                cq_base_we,
   input  logic [ADDR_W-1:0]   cq_base_wd,
   input  logic [DLY_W-1:0]    rdy_dly,
   input  logic                eng_idle,
   output logic [CFG_W-1:0]    cfg_q,
   output logic [ACT_W-1:0]    act_cfg,
   output logic [2*QSZ_W-1:0]  adm_size_q,
   output logic [ADDR_W-1:0]   sq_base_q,
   output logic [ADDR_W-1:0]   cq_base_q,
   output logic                ready,
   output logic                fatal,
   output logic [1:0]          sd_status,
   output logic                drain_req,
   output logic                ioq_flush
);

   generate
      if (CFG_W < FIELD_LO + 1) begin : g_bad_cfg_w
         $error("CFG_W must leave at least one settings bit");
      end
      if (QSZ_W < 2) begin : g_bad_qsz_w
         $error("QSZ_W must be at least 2");
      end
      if (DLY_W < 1) begin : g_bad_dly_w
         $error("DLY_W must be at least 1");
      end
   endgenerate

   logic take, ctl_rst, live, fsm_drain;

   cfg_bank #(.CFG_W(CFG_W), .QSZ_W(QSZ_W), .ADDR_W(ADDR_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_rst (bus_rst),
      .cfg_we  (cfg_we),
      .cfg_wd  (cfg_wd),
      .size_we (adm_size_we),
      .size_wd (adm_size_wd),
      .sqb_we  (sq_base_we),
      .sqb_wd  (sq_base_wd),
      .cqb_we  (cq_base_we),
      .cqb_wd  (cq_base_wd),
      .take    (take),
      .cfg_q   (cfg_q),
      .act_q   (act_cfg),
      .size_q  (adm_size_q),
      .sqb_q   (sq_base_q),
      .cqb_q   (cq_base_q)
   );

   seq_fsm #(.QSZ_W(QSZ_W), .DLY_W(DLY_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_rst  (bus_rst),
      .en       (cfg_q[EN_BIT]),
      .sq_sz    (adm_size_q[QSZ_W-1:0]),
      .cq_sz    (adm_size_q[2*QSZ_W-1:QSZ_W]),
      .dly      (rdy_dly),
      .eng_idle (eng_idle),
      .take     (take),
      .ctl_rst  (ctl_rst),
      .live     (live),
      .rdy      (ready),
      .fault    (fatal),
      .drain    (fsm_drain),
      .flush    (ioq_flush)
   );

   sd_track #(.ABRUPT_SKIPS_DRAIN(ABRUPT_SKIPS_DRAIN)) u_sd (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (ctl_rst),
      .live      (live),
      .sd_req    (cfg_q[SDR_LO+1:SDR_LO]),
      .eng_idle  (eng_idle),
      .sd_status (sd_status)
   );

   assign drain_req = fsm_drain | (sd_status == SD_BUSY);

   AST_FLUSH_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (ioq_flush && !bus_rst) |=> !ioq_flush); // R5

   AST_BUS_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_rst) |-> (!ready && !fatal && sd_status == SD_NONE && cfg_q == '0
                          && ioq_flush)); // R10

endmodule

// File: tb/ctrl_enable_seq_bench.sv
module ctrl_enable_seq_bench;
   localparam int CFG_W  = 16;
   localparam int QSZ_W  = 12;
   localparam int ADDR_W = 32;
   localparam int DLY_W  = 8;
   localparam int ACT_W  = CFG_W - 3;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                bus_rst = 1'b0;
   logic                cfg_we = 1'b0;
   logic [CFG_W-1:0]    cfg_wd = '0;
   logic                adm_size_we = 1'b0;
   logic [2*QSZ_W-1:0]  adm_size_wd = '0;
   logic                sq_base_we = 1'b0;
   logic [ADDR_W-1:0]   sq_base_wd = '0;
   logic                cq_base_we = 1'b0;
   logic [ADDR_W-1:0]   cq_base_wd = '0;
   logic [DLY_W-1:0]    rdy_dly = '0;
   logic                eng_idle = 1'b1;
   logic [CFG_W-1:0]    cfg_q;
   logic [ACT_W-1:0]    act_cfg;
   logic [2*QSZ_W-1:0]  adm_size_q;
   logic [ADDR_W-1:0]   sq_base_q;
   logic [ADDR_W-1:0]   cq_base_q;
   logic                ready, fatal, drain_req, ioq_flush;
   logic [1:0]          sd_status;

   int vecs = 0;
   int errs = 0;

   // 125 MHz: 8 time units per period
   always #4 clk = ~clk;

   ctrl_enable_seq u_ctrl_enable_seq (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
      .cfg_we(cfg_we), .cfg_wd(cfg_wd),
      .adm_size_we(adm_size_we), .adm_size_wd(adm_size_wd),
      .sq_base_we(sq_base_we), .sq_base_wd(sq_base_wd),
      .cq_base_we(cq_base_we), .cq_base_wd(cq_base_wd),
      .rdy_dly(rdy_dly), .eng_idle(eng_idle),
      .cfg_q(cfg_q), .act_cfg(act_cfg), .adm_size_q(adm_size_q),
      .sq_base_q(sq_base_q), .cq_base_q(cq_base_q),
      .ready(ready), .fatal(fatal), .sd_status(sd_status),
      .drain_req(drain_req), .ioq_flush(ioq_flush)
   );

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr_cfg(input logic [CFG_W-1:0] d);
      cfg_we = 1'b1;
      cfg_wd = d;
      step();
      cfg_we = 1'b0;
   endtask

   // bench model of the configuration lock rule
   function automatic logic [CFG_W-1:0] cfg_model(input logic [CFG_W-1:0] old,
                                                  input logic [CFG_W-1:0] d);
      if (old[0]) return {old[CFG_W-1:3], d[2:0]};
      return d;
   endfunction

   function automatic logic [CFG_W-1:0] mk_cfg(input logic [ACT_W-1:0] f,
                                                input logic [1:0] sd, input logic en);
      return {f, sd, en};
   endfunction

   // enable from the disabled state and wait until ready is due
   task automatic go_live(input int dly, input logic [ACT_W-1:0] f);
      rdy_dly = DLY_W'(dly);
      wr_cfg(mk_cfg(f, 2'b00, 1'b1));
      repeat (dly + 2) step();
   endtask

   // disable with an idle engine: drain edge then off edge
   task automatic go_off();
      eng_idle = 1'b1;
      wr_cfg(cfg_q & ~CFG_W'(7));
      repeat (2) step();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: actual expired expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin : main
      logic [CFG_W-1:0]   mcfg;
      logic [2*QSZ_W-1:0] msize;
      logic [ADDR_W-1:0]  msqb, mcqb;
      logic [ACT_W-1:0]   f1, f2;
      int                 dl [4];
      int                 seed_dummy;
      seed_dummy = $urandom(32'h5eed_c0de);

      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 ready", ready, 0);
      chk("R1 fatal", fatal, 0);
      chk("R1 sd_status", sd_status, 0);
      chk("R1 drain_req", drain_req, 0);
      chk("R1 ioq_flush", ioq_flush, 0);
      chk("R1 regs", {cfg_q, act_cfg, adm_size_q, sq_base_q, cq_base_q}, 0);

      // R6 enable with zero admin sizes
      wr_cfg(mk_cfg(13'h0A5, 2'b00, 1'b1));
      repeat (3) step();
      chk("R6 fatal set", fatal, 1);
      chk("R6 ready held low", ready, 0);
      wr_cfg(mk_cfg(13'h0A5, 2'b00, 1'b0));
      step();
      chk("R6 fatal cleared", fatal, 0);
      step();

      // R11 admin register writes
      msize = {12'd7, 12'd15};
      msqb  = $urandom;
      mcqb  = $urandom;
      adm_size_we = 1'b1; adm_size_wd = msize;
      sq_base_we  = 1'b1; sq_base_wd  = msqb;
      cq_base_we  = 1'b1; cq_base_wd  = mcqb;
      step();
      adm_size_we = 1'b0; sq_base_we = 1'b0; cq_base_we = 1'b0;
      chk("R11 sizes", adm_size_q, msize);
      chk("R11 sq base", sq_base_q, msqb);
      chk("R11 cq base", cq_base_q, mcqb);

      // R3 / R4 wake-up timing for several delays
      dl[0] = 0; dl[1] = 1; dl[2] = 5; dl[3] = 2 + int'($urandom % 20);
      foreach (dl[i]) begin
         f1 = ACT_W'($urandom);
         f2 = ~f1;
         rdy_dly = DLY_W'(dl[i]);
         wr_cfg(mk_cfg(f1, 2'b00, 1'b1));
         chk("R3 ready low at write", ready, 0);
         repeat (dl[i] + 1) step();
         chk("R3 ready still low", ready, 0);
         step();
         chk("R3 ready on time", ready, 1);
         chk("R4 active settings", act_cfg, f1);
         wr_cfg(mk_cfg(f2, 2'b00, 1'b1));
         chk("R2 settings locked", cfg_q, mk_cfg(f1, 2'b00, 1'b1));
         step();
         chk("R4 active unchanged", act_cfg, f1);
         go_off();
         chk("R5 off after idle drain", ready, 0);
      end

      // R4 settings written while disabled only take effect at enable
      f1 = 13'h1234;
      wr_cfg(mk_cfg(f1, 2'b00, 1'b0));
      chk("R2 full write when disabled", cfg_q, mk_cfg(f1, 2'b00, 1'b0));
      chk("R4 not yet active", act_cfg === f1 ? 1'b0 : 1'b1, 1);

      // R5 disable with busy engine
      go_live(0, f1);
      chk("R4 active after enable", act_cfg, f1);
      eng_idle = 1'b0;
      wr_cfg(mk_cfg(f1, 2'b00, 1'b0));
      chk("R5 no drain at write edge", drain_req, 0);
      step();
      chk("R5 drain asserted", drain_req, 1);
      chk("R5 ready held", ready, 1);
      repeat (4) step();
      chk("R5 still draining", {drain_req, ready}, 2'b11);
      eng_idle = 1'b1;
      step();
      chk("R5 ready low after idle", ready, 0);
      chk("R5 drain released", drain_req, 0);
      chk("R5 flush pulse", ioq_flush, 1);
      step();
      chk("R5 flush one cycle", ioq_flush, 0);
      chk("R9 admin kept", {adm_size_q, sq_base_q, cq_base_q}, {msize, msqb, mcqb});

      // R7 normal shutdown
      go_live(0, f1);
      eng_idle = 1'b0;
      wr_cfg(mk_cfg(f1, 2'b01, 1'b1));
      chk("R7 status before", sd_status, 2'b00);
      step();
      chk("R7 in progress", sd_status, 2'b01);
      chk("R7 drain requested", drain_req, 1);
      repeat (3) step();
      chk("R7 waits for idle", sd_status, 2'b01);
      eng_idle = 1'b1;
      step();
      chk("R7 complete", sd_status, 2'b10);
      wr_cfg(mk_cfg(f1, 2'b00, 1'b0));
      repeat (2) step();
      chk("R9 status cleared by reset", sd_status, 2'b00);
      chk("R9 ready low", ready, 0);
      chk("R9 admin kept", {adm_size_q, sq_base_q, cq_base_q}, {msize, msqb, mcqb});

      // R8 abrupt shutdown ignores engine state
      go_live(3, f1);
      eng_idle = 1'b0;
      wr_cfg(mk_cfg(f1, 2'b10, 1'b1));
      step();
      chk("R8 in progress", sd_status, 2'b01);
      step();
      chk("R8 complete without idle", sd_status, 2'b10);

      // R10 bus reset
      bus_rst = 1'b1;
      step();
      bus_rst = 1'b0;
      chk("R10 ready", ready, 0);
      chk("R10 status", sd_status, 2'b00);
      chk("R10 cfg word", cfg_q, 0);
      chk("R10 flush", ioq_flush, 1);
      chk("R10 drain", drain_req, 0);
      chk("R10 fatal", fatal, 0);
      chk("R10 admin kept", {adm_size_q, sq_base_q, cq_base_q}, {msize, msqb, mcqb});
      chk("R10 active kept", act_cfg, f1);
      step();
      chk("R10 flush ends", ioq_flush, 0);

      // R2 / R11 constrained random configuration and admin traffic
      eng_idle = 1'b1;
      rdy_dly  = 8'd2;
      mcfg = '0;
      for (int n = 0; n < 400; n++) begin
         logic [CFG_W-1:0] d;
         logic             aw;
         d  = CFG_W'($urandom);
         aw = ($urandom % 4) == 0;
         cfg_we = ($urandom % 3) != 0;
         cfg_wd = d;
         if (aw) begin
            msize = {12'd1 + 12'($urandom % 4000), 12'd1 + 12'($urandom % 4000)};
            adm_size_we = 1'b1;
            adm_size_wd = msize;
         end
         if (cfg_we) mcfg = cfg_model(mcfg, d);
         step();
         cfg_we = 1'b0;
         adm_size_we = 1'b0;
         chk("R2 random cfg", cfg_q, mcfg);
         chk("R11 random sizes", adm_size_q, msize);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule